// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Aligner

This block sits between a 32-bit, word-aligned instruction memory port and an instruction decoder in a core that mixes 16-bit compressed instructions with 32-bit ones. It reads whole words at the word address of the program counter and cuts each word into two 16-bit parcels. It decides from the first parcel how long the instruction is, and hands the decoder one instruction per handshake, together with its address and a compressed flag. A 32-bit instruction may start in the upper parcel of a word and end in the next word. The block keeps that upper parcel in a one-parcel buffer and joins it with the lower parcel of the following word. Once a word has been read, its unused upper parcel stays in the buffer marked as prefetched, so the instruction that starts there needs no second read of the same word.

A build-time switch selects the parcel order of the stream. In the swapped order, bits [31:16] of each memory word are the parcel that comes first and supply the lower instruction bits. The swap is applied to the word before anything else uses it, which includes the holding buffer. A redirect input (taken branch, jump or trap) loads a new program counter and drops everything already buffered.

The control is a three-state machine. FETCH chooses the first parcel. It takes the buffered parcel when the prefetch mark is set and the PC points at an upper half; otherwise it issues a memory read. From FETCH the machine moves to ISSUE when a full instruction is known (the *complete* transition), or to SECOND when a 32-bit instruction begins in an upper parcel (the *straddle* transition). SECOND reads the next word and moves to ISSUE (the *join* transition). ISSUE offers the instruction to the decoder. On acceptance it steps the PC and returns to FETCH (the *advance* transition). From any state a redirect returns the machine to FETCH (the *flush* transition).

Top module: `fetch_aligner`

## Requirements
- R1: Every memory read address has bits [1:0] equal to zero. A first read targets the word holding the PC; the read for the second half of a 32-bit instruction that starts in an upper parcel targets the following word (PC word index plus one).
- R2: With `BIG_PARCEL_ORDER` = 0, bits [15:0] of a memory word are the parcel at the lower address. With `BIG_PARCEL_ORDER` = 1, bits [31:16] are that parcel. In both orders the parcel at the lower address supplies instruction bits [15:0].
- R3: A parcel with bits [1:0] = 2'b11 starts a 32-bit instruction; any other value starts a 16-bit instruction. `ins_compressed_o` is 1 exactly for 16-bit instructions, and a 16-bit instruction is presented zero-extended in `ins_data_o`.
- R4: A 32-bit instruction whose first parcel is the upper parcel of word k is presented as {lower parcel of word k+1, upper parcel of word k}.
- R5: The upper parcel of a word is kept as prefetched after a 16-bit instruction in that word's lower half, and after the join of a straddling instruction. An instruction that starts in such a kept parcel causes no memory read if it is 16-bit, and exactly one read (the following word) if it is 32-bit.
- R6: `ins_pc_o` is the byte address of the presented instruction. After the decoder accepts an instruction, the next one presented is at that address plus 2 (16-bit) or plus 4 (32-bit).
- R7: A redirect discards the prefetched parcel, any pending second-word read and any instruction not yet accepted. The next instruction presented is the one at the redirect address, with bit 0 of that address ignored.
- R8: While `ins_valid_o` is 1 and `ins_ready_i` is 0, with no redirect, the presented instruction, its flag and its address stay unchanged in the next cycle.
- R9: During and right after reset no instruction is presented, the prefetch mark is clear and the PC equals `RESET_ADDR`. A reset address with bit 1 set starts fetching at the upper parcel of its word.
- R10: While `mem_valid_o` is 1 and `mem_ready_i` is 0, with no redirect, the request and its address are held in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Load a new PC and flush buffered state |
| redirect_pc_i | input | 32 | New PC applied with `redirect_i` |
| mem_valid_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Word-aligned read address |
| mem_ready_i | input | 1 | Read completes this cycle; `mem_rdata_i` valid |
| mem_rdata_i | input | 32 | Read data word |
| ins_valid_o | output | 1 | Instruction presented to the decoder |
| ins_data_o | output | 32 | Instruction bits, 16-bit ones zero-extended |
| ins_compressed_o | output | 1 | Presented instruction is 16-bit |
| ins_pc_o | output | 32 | Byte address of presented instruction |
| ins_ready_i | input | 1 | Decoder accepts the presented instruction |

## Verification
The bench runs a generated program of mixed 16/32-bit instructions through two instances at once: one in natural parcel order starting at address 0, and one in swapped order starting at address 2. Both see irregular memory and decoder back-pressure. A design that joins the two halves of a straddling instruction the wrong way round, fills the buffer from the raw word instead of the reordered one, or mishandles a reset address in an upper half presents wrong instruction bits or wrong addresses. Reads are counted against a count derived from the prefetch rule, so a design that re-reads a word it already holds, or skips a needed second read, is caught. A redirect is raised while a prefetched parcel is live and the target lies in the upper half of a different word; a design that keeps the stale parcel presents it in place of the target instruction.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int PARCEL_W = 16;
    localparam int WORD_W   = 2 * PARCEL_W;
    localparam int ADDR_W   = 32;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_SECOND = 2'd1,
        ST_ISSUE  = 2'd2
    } fa_state_e;
endpackage

// File: rtl/fa_parcel_order.sv
module fa_parcel_order #(
    parameter int  WIDTH = 32,
    parameter bit  SWAP  = 1'b0
) (
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] ord_o
);
    localparam int HALF = WIDTH / 2;

    generate
        if (SWAP) begin : g_swap
            assign ord_o = {raw_i[HALF-1:0], raw_i[WIDTH-1:HALF]};
        end else begin : g_keep
            assign ord_o = raw_i;
        end
    endgenerate
endmodule

// File: rtl/fa_len_detect.sv
module fa_len_detect #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] parcel_i,
    output logic          wide_o
);
    // Both low bits set marks the first parcel of a full-length instruction.
    assign wide_o = &parcel_i[1:0];
endmodule

// File: rtl/fa_pc_step.sv
module fa_pc_step #(
    parameter int AW       = 32,
    parameter int PARCEL_B = 2
) (
    input  logic [AW-1:0] pc_i,
    input  logic          short_i,
    output logic [AW-1:0] pc_o
);
    localparam int WORD_B = 2 * PARCEL_B;

    assign pc_o = pc_i + (short_i ? AW'(PARCEL_B) : AW'(WORD_B));
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
    import fa_pkg::*;
#(
    parameter logic [31:0] RESET_ADDR       = 32'h0000_0000,
    parameter bit          BIG_PARCEL_ORDER = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        redirect_i,
    input  logic [31:0] redirect_pc_i,
    output logic        mem_valid_o,
    output logic [31:0] mem_addr_o,
    input  logic        mem_ready_i,
    input  logic [31:0] mem_rdata_i,
    output logic        ins_valid_o,
    output logic [31:0] ins_data_o,
    output logic        ins_compressed_o,
    output logic [31:0] ins_pc_o,
    input  logic        ins_ready_i
);
    localparam int PARCEL_B = PARCEL_W / 8;
    localparam int WIDX_W   = ADDR_W - 2;

    fa_state_e             state_q, state_d;
    logic [ADDR_W-1:0]     pc_q, pc_d;
    logic [PARCEL_W-1:0]   buf_q, buf_d;
    logic                  pf_q, pf_d;
    logic [WORD_W-1:0]     ins_q, ins_d;
    logic                  comp_q, comp_d;

    logic [WORD_W-1:0]     word_w;
    logic [PARCEL_W-1:0]   lo_w, hi_w, first_w;
    logic                  use_buf_w, first_wide_w;
    logic [ADDR_W-1:0]     pc_next_w;
    logic [WIDX_W-1:0]     widx_w;

    fa_parcel_order #(.WIDTH(WORD_W), .SWAP(BIG_PARCEL_ORDER)) u_order (
        .raw_i (mem_rdata_i),
        .ord_o (word_w)
    );

    assign lo_w      = word_w[PARCEL_W-1:0];
    assign hi_w      = word_w[WORD_W-1:PARCEL_W];
    assign use_buf_w = pf_q && pc_q[1];
    assign first_w   = use_buf_w ? buf_q : (pc_q[1] ? hi_w : lo_w);

    fa_len_detect #(.PW(PARCEL_W)) u_len (
        .parcel_i (first_w),
        .wide_o   (first_wide_w)
    );

    fa_pc_step #(.AW(ADDR_W), .PARCEL_B(PARCEL_B)) u_step (
        .pc_i    (pc_q),
        .short_i (comp_q),
        .pc_o    (pc_next_w)
    );

    // Next-state and datapath selection
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        buf_d   = buf_q;
        pf_d    = pf_q;
        ins_d   = ins_q;
        comp_d  = comp_q;
        unique case (state_q)
            ST_FETCH: begin
                if (use_buf_w) begin
                    pf_d = 1'b0;
                    if (!first_wide_w) begin
                        ins_d   = {{PARCEL_W{1'b0}}, buf_q};
                        comp_d  = 1'b1;
                        state_d = ST_ISSUE;
                    end else begin
                        state_d = ST_SECOND;
                    end
                end else if (mem_ready_i) begin
                    if (!pc_q[1]) begin
                        if (!first_wide_w) begin
                            ins_d  = {{PARCEL_W{1'b0}}, lo_w};
                            comp_d = 1'b1;
                            buf_d  = hi_w;
                            pf_d   = 1'b1;
                        end else begin
                            ins_d  = word_w;
                            comp_d = 1'b0;
                            pf_d   = 1'b0;
                        end
                        state_d = ST_ISSUE;
                    end else begin
                        pf_d = 1'b0;
                        if (!first_wide_w) begin
                            ins_d   = {{PARCEL_W{1'b0}}, hi_w};
                            comp_d  = 1'b1;
                            state_d = ST_ISSUE;
                        end else begin
                            buf_d   = hi_w;
                            state_d = ST_SECOND;
                        end
                    end
                end
            end
            ST_SECOND: begin
                if (mem_ready_i) begin
                    ins_d   = {lo_w, buf_q};
                    comp_d  = 1'b0;
                    buf_d   = hi_w;
                    pf_d    = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (ins_ready_i) begin
                    pc_d    = pc_next_w;
                    state_d = ST_FETCH;
                end
            end
            default: state_d = ST_FETCH;
        endcase
        if (redirect_i) begin
            pc_d    = redirect_pc_i & 32'hFFFF_FFFE;
            pf_d    = 1'b0;
            state_d = ST_FETCH;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= RESET_ADDR & 32'hFFFF_FFFE;
            buf_q   <= '0;
            pf_q    <= 1'b0;
            ins_q   <= '0;
            comp_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            buf_q   <= buf_d;
            pf_q    <= pf_d;
            ins_q   <= ins_d;
            comp_q  <= comp_d;
        end
    end

    // Outputs
    assign widx_w = pc_q[ADDR_W-1:2] + WIDX_W'(state_q == ST_SECOND);

    always_comb begin
        mem_valid_o      = (state_q == ST_SECOND) || (state_q == ST_FETCH && !use_buf_w);
        mem_addr_o       = {widx_w, 2'b00};
        ins_valid_o      = (state_q == ST_ISSUE);
        ins_data_o       = ins_q;
        ins_compressed_o = comp_q;
        ins_pc_o         = pc_q;
    end

    // R1
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> (mem_addr_o[1:0] == 2'b00));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i && !redirect_i) |=> (mem_valid_o && $stable(mem_addr_o)));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_o && !ins_ready_i && !redirect_i) |=>
            (ins_valid_o && $stable(ins_data_o) && $stable(ins_pc_o) && $stable(ins_compressed_o)));

    // R3
    len_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid_o |-> (ins_compressed_o == (ins_data_o[1:0] != 2'b11)));

    // R6
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_o && ins_ready_i && !redirect_i) |=>
            ((pc_q - $past(ins_pc_o)) == ($past(ins_compressed_o) ? 32'd2 : 32'd4)));

    // R7
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (!ins_valid_o && !pf_q && (pc_q == ($past(redirect_pc_i) & 32'hFFFF_FFFE))));

    // R5
    no_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && pf_q && pc_q[1]) |-> !mem_valid_o);
endmodule

// File: tb/sim_fetch_aligner.sv
module sim_fetch_aligner;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] par [0:2*NW-1];
    logic [31:0] lew [0:NW-1];
    logic [31:0] bew [0:NW-1];
    logic [31:0] st  [0:NW-1];
    logic [31:0] exd [0:NW-1];
    bit          exc [0:NW-1];
    int M, NI, L0, T;

    logic        rdr_v = 1'b0;
    logic [31:0] rdr_pc = '0;
    logic        rdy0 = 1'b0, rdy1 = 1'b0, mrdy0 = 1'b0, mrdy1 = 1'b0;

    logic        m0_v, m1_v, i0_v, i1_v, c0, c1;
    logic [31:0] m0_a, m1_a, d0, d1, p0, p1, m0_d, m1_d;

    assign m0_d = lew[m0_a[7:2]];
    assign m1_d = bew[m1_a[7:2]];

    fetch_aligner #(.RESET_ADDR(32'h0), .BIG_PARCEL_ORDER(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .redirect_i(rdr_v), .redirect_pc_i(rdr_pc),
        .mem_valid_o(m0_v), .mem_addr_o(m0_a), .mem_ready_i(mrdy0), .mem_rdata_i(m0_d),
        .ins_valid_o(i0_v), .ins_data_o(d0), .ins_compressed_o(c0), .ins_pc_o(p0),
        .ins_ready_i(rdy0));

    fetch_aligner #(.RESET_ADDR(32'h2), .BIG_PARCEL_ORDER(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .redirect_i(1'b0), .redirect_pc_i(32'h0),
        .mem_valid_o(m1_v), .mem_addr_o(m1_a), .mem_ready_i(mrdy1), .mem_rdata_i(m1_d),
        .ins_valid_o(i1_v), .ins_data_o(d1), .ins_compressed_o(c1), .ins_pc_o(p1),
        .ins_ready_i(rdy1));

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reads implied by the prefetch rule for instructions s..e-1 from a cold start
    function automatic int acc_count(input int s, input int e);
        bit pf = 1'b0;
        int a = 0;
        for (int i = s; i < e; i++) begin
            if (!st[i][1]) begin
                a++;
                pf = exc[i];
            end else if (pf) begin
                if (exc[i]) pf = 1'b0;
                else a++;
            end else begin
                a++;
                if (!exc[i]) begin a++; pf = 1'b1; end
            end
        end
        return a;
    endfunction

    task automatic chk_ins(input string tag, input int k, input logic [31:0] d,
                           input bit c, input logic [31:0] p);
        chk(d == exd[k], {tag, " R2 R3 R4 data"}, d, exd[k]);
        chk(c == exc[k], {tag, " R3 compressed flag"}, 32'(c), 32'(exc[k]));
        chk(p == st[k],  {tag, " R6 address"}, p, st[k]);
    endtask

    // Program image
    initial begin
        int p = 0;
        M = 0;
        for (int i = 0; i < 2*NW; i++) par[i] = 16'h0001;
        for (int i = 0; i < NW; i++) begin
            bit c = (i == 0) || (((32'h5A3C_96E1 >> (i % 32)) & 1) == 1);
            if (p + (c ? 1 : 2) > 2*NW - 4) break;
            st[i] = 32'(p * 2);
            exc[i] = c;
            if (c) begin
                par[p] = {8'(i), 6'h15, 2'b01};
                exd[i] = {16'h0, par[p]};
                p = p + 1;
            end else begin
                par[p]   = {8'(i), 6'h2A, 2'b11};
                par[p+1] = {8'hC3, 8'(i)};
                exd[i]   = {par[p+1], par[p]};
                p = p + 2;
            end
            M = i + 1;
        end
        for (int k = 0; k < NW; k++) begin
            lew[k] = {par[2*k+1], par[2*k]};
            bew[k] = {par[2*k], par[2*k+1]};
        end
        NI = M - 1;
        L0 = -1;
        T  = -1;
        for (int i = 2; i < NI; i++)
            if (L0 < 0 && exc[i] && !st[i][1]) L0 = i;
        for (int j = L0 + 3; j + 7 < NI; j++)
            if (T < 0 && st[j][1] && (st[j][31:2] != st[L0][31:2])) T = j;
    end

    int cyc = 0, phase = 0, step = 0;
    int idx0 = 0, idx1 = 1, acc0 = 0, acc1 = 0;
    bit ohold = 1'b0, mhold = 1'b0;
    logic [31:0] ohold_d, ohold_p, mhold_a;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            mrdy0 = (cyc % 3) != 1;
            mrdy1 = (cyc % 4) != 0;
            if (phase == 1) begin
                // R8 / R10: values held from the previous stalled cycle
                if (ohold) begin
                    chk(i0_v && d0 == ohold_d && p0 == ohold_p, "R8 stall hold", d0, ohold_d);
                end
                if (mhold) begin
                    chk(m0_v && m0_a == mhold_a, "R10 request hold", m0_a, mhold_a);
                end
                rdy0 = (idx0 < NI) && ((cyc % 5) != 3);
                rdy1 = (idx1 < NI) && ((cyc % 7) != 2);
                ohold = i0_v && !rdy0;
                ohold_d = d0;
                ohold_p = p0;
                mhold = m0_v && !mrdy0;
                mhold_a = m0_a;
                if (m0_v && mrdy0 && idx0 < NI) begin
                    acc0++;
                    chk(m0_a[1:0] == 2'b00, "R1 alignment", m0_a, {m0_a[31:2], 2'b00});
                end
                if (m1_v && mrdy1 && idx1 < NI) acc1++;
                if (i0_v && rdy0) begin
                    chk_ins("u0", idx0, d0, c0, p0);
                    idx0++;
                end
                if (i1_v && rdy1) begin
                    chk_ins("u1", idx1, d1, c1, p1);
                    idx1++;
                end
                if (idx0 == NI && idx1 == NI) begin
                    chk(acc0 == acc_count(0, NI), "R5 R1 read count u0", 32'(acc0), 32'(acc_count(0, NI)));
                    chk(acc1 == acc_count(1, NI), "R5 R9 read count u1", 32'(acc1), 32'(acc_count(1, NI)));
                    phase = 2;
                    step = 0;
                    ohold = 1'b0;
                    mhold = 1'b0;
                end
            end else if (phase == 2) begin
                rdy0 = 1'b0;
                rdy1 = 1'b0;
                if (step == 0) begin
                    rdr_v = 1'b1;
                    rdr_pc = st[L0] | 32'h1;
                    idx0 = L0;
                    step = 1;
                end else if (step == 1) begin
                    rdr_v = 1'b0;
                    if (i0_v) begin
                        chk_ins("R7 first target", L0, d0, c0, p0);
                        rdr_v = 1'b1;
                        rdr_pc = st[T];
                        idx0 = T;
                        step = 2;
                    end
                end else begin
                    rdr_v = 1'b0;
                    rdy0 = (cyc % 2) == 0;
                    if (i0_v && rdy0) begin
                        chk_ins("R7 after flush", idx0, d0, c0, p0);
                        idx0++;
                        if (idx0 == T + 6) done = 1'b1;
                    end
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!i0_v && !i1_v, "R9 no instruction in reset", 32'(i0_v | i1_v), 32'h0);
        chk(m0_v && m0_a == 32'h0, "R9 R1 u0 first read", m0_a, 32'h0);
        chk(m1_v && m1_a == 32'h0, "R9 R1 u1 upper-half start read", m1_a, 32'h0);
        rst_n = 1'b1;
        phase = 1;
        while (!done && cyc < 20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", idx0, NI);
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule